// File: doc/BRIEF.md
# Superpoly Accumulator with Per-Round Balance Counters

This block sits behind an array of parallel cipher instances that are being queried over a cube of IV bits. On every cycle in which the array presents a valid run, it XORs the 32-bit output words of all instances into one word. It then folds that word into a running intermediate word. After all runs for one key are done, the intermediate word holds the superpoly value for that key. Bit i of the word belongs to the i-th of 32 consecutive initialization round counts, so one pass measures 32 round counts side by side.

An end-of-trial strobe closes the current key. Each bit lane then adds one to either its zero tally or its one tally, according to the lane's final superpoly bit. The trial count advances and the intermediate word returns to zero for the next key. After many trials with distinct keys, the ratio between each lane's two tallies shows whether the superpoly at that round count is biased. A done flag reports that a programmed number of trials has been reached. A clear input restarts the whole statistic.

Top module: `superpoly_acc`

## Requirements
- R1: After the synchronous active-high reset, every zero tally, every one tally and the trial count read 0, and done is low.
- R2: On a cycle with run_vld high, the XOR of all NUM_INST instance words is XORed into the intermediate word. Two identical runs therefore cancel, and an odd number of identical runs leaves the word in place.
- R3: On a cycle with run_vld low, the instance words have no effect: a trial closed afterwards counts only the runs that were valid.
- R4: On a cycle with trial_end high and clr low, lane i increments its one tally if its final superpoly bit is 1 and its zero tally if that bit is 0. The trial count increments by one, and the intermediate word is zero for the next trial. The tallies and the trial count change on the clock edge of that cycle and on no other edge.
- R5: When run_vld and trial_end are high in the same cycle, that run's reduced word is folded into the final value before the lanes are tallied.
- R6: Each tally is CNT_W bits wide and holds at 2^CNT_W-1 instead of wrapping.
- R7: The trial count is TRIAL_W bits wide and holds at 2^TRIAL_W-1 instead of wrapping.
- R8: clr high zeroes all tallies, the trial count and the intermediate word on the next edge, and lowers done. It takes priority over run_vld and trial_end in the same cycle.
- R9: done is high exactly when trial_limit is non-zero and the trial count is at least trial_limit. It changes on the same edge as the trial count. A limit of 0 keeps done low.
- R10: Instance j drives inst_words[LANES*j +: LANES], and bit i of each word feeds lane i. Lane i's tallies appear at zero_cnt[CNT_W*i +: CNT_W] and one_cnt[CNT_W*i +: CNT_W].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Restart all statistics |
| run_vld | input | 1 | Instance words are valid this cycle |
| inst_words | input | NUM_INST*LANES | Output words of all instances, packed |
| trial_end | input | 1 | Close the current key's trial |
| trial_limit | input | TRIAL_W | Trial count at which done rises (0 disables) |
| zero_cnt | output | LANES*CNT_W | Per-lane tally of zero superpoly values |
| one_cnt | output | LANES*CNT_W | Per-lane tally of one superpoly values |
| trial_cnt | output | TRIAL_W | Number of trials closed |
| done | output | 1 | Trial limit reached |

## Verification
The run fold and the trial close can fall in the same cycle, and so can a clear with either of them. The bench provokes these collisions in directed steps and also lets random stimulus land run_vld and trial_end together. Each tally is judged against a bench model that folds the coinciding run into the final word before tallying, and that lets a clear win over both. A few more directed steps close a trial with run_vld low and changing words, to show that those words are ignored.

// File: rtl/spa_pkg.sv
package spa_pkg;
  // Decoded control for one cycle.
  typedef struct packed {
    logic wipe;   // restart everything
    logic fold;   // fold reduced word into intermediate
    logic close;  // tally lanes, advance trial count
  } spa_ctl_t;

  function automatic spa_ctl_t spa_decode(input logic clr, input logic run_vld,
                                          input logic trial_end);
    spa_ctl_t c;
    c.wipe  = clr;
    c.fold  = run_vld & ~clr;
    c.close = trial_end & ~clr;
    return c;
  endfunction
endpackage

// File: rtl/spa_xor_reduce.sv
module spa_xor_reduce #(
  parameter int unsigned NUM_INST = 4,
  parameter int unsigned LANES    = 32
) (
  input  logic [NUM_INST*LANES-1:0] words,
  output logic [LANES-1:0]          reduced
);
  always_comb begin
    reduced = '0;
    for (int j = 0; j < NUM_INST; j++) begin
      reduced = reduced ^ words[LANES*j +: LANES];
    end
  end
endmodule

// File: rtl/spa_lane_tally.sv
module spa_lane_tally #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wipe,
  input  logic             close,
  input  logic             bit_val,
  output logic [CNT_W-1:0] zero_q,
  output logic [CNT_W-1:0] one_q
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst || wipe) begin
      zero_q <= '0;
      one_q  <= '0;
    end else if (close) begin
      if (bit_val) begin
        if (one_q != TOP) one_q <= one_q + 1'b1;
      end else begin
        if (zero_q != TOP) zero_q <= zero_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spa_trial_ctl.sv
module spa_trial_ctl #(
  parameter int unsigned TRIAL_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wipe,
  input  logic               close,
  input  logic [TRIAL_W-1:0] limit,
  output logic [TRIAL_W-1:0] trial_q,
  output logic               done_q
);
  localparam logic [TRIAL_W-1:0] TOP = {TRIAL_W{1'b1}};

  logic [TRIAL_W-1:0] trial_nxt;

  always_comb begin
    trial_nxt = trial_q;
    if (wipe) trial_nxt = '0;
    else if (close && trial_q != TOP) trial_nxt = trial_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trial_q <= '0;
      done_q  <= 1'b0;
    end else begin
      trial_q <= trial_nxt;
      done_q  <= (limit != '0) && (trial_nxt >= limit);
    end
  end
endmodule

// File: rtl/superpoly_acc.sv
module superpoly_acc #(
  parameter int unsigned NUM_INST = 4,
  parameter int unsigned LANES    = 32,
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned TRIAL_W  = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      clr,
  input  logic                      run_vld,
  input  logic [NUM_INST*LANES-1:0] inst_words,
  input  logic                      trial_end,
  input  logic [TRIAL_W-1:0]        trial_limit,
  output logic [LANES*CNT_W-1:0]    zero_cnt,
  output logic [LANES*CNT_W-1:0]    one_cnt,
  output logic [TRIAL_W-1:0]        trial_cnt,
  output logic                      done
);
  import spa_pkg::*;

  spa_ctl_t         ctl;
  logic [LANES-1:0] reduced;
  logic [LANES-1:0] inter_q;
  logic [LANES-1:0] final_word;

  assign ctl = spa_decode(clr, run_vld, trial_end);

  spa_xor_reduce #(.NUM_INST(NUM_INST), .LANES(LANES)) u_reduce (
    .words   (inst_words),
    .reduced (reduced)
  );

  // A run arriving with the close is part of the closing value.
  assign final_word = inter_q ^ (ctl.fold ? reduced : '0);

  always_ff @(posedge clk) begin
    if (rst || ctl.wipe || ctl.close) inter_q <= '0;
    else                              inter_q <= final_word;
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    spa_lane_tally #(.CNT_W(CNT_W)) u_tally (
      .clk     (clk),
      .rst     (rst),
      .wipe    (ctl.wipe),
      .close   (ctl.close),
      .bit_val (final_word[i]),
      .zero_q  (zero_cnt[CNT_W*i +: CNT_W]),
      .one_q   (one_cnt[CNT_W*i +: CNT_W])
    );
  end

  spa_trial_ctl #(.TRIAL_W(TRIAL_W)) u_trial (
    .clk     (clk),
    .rst     (rst),
    .wipe    (ctl.wipe),
    .close   (ctl.close),
    .limit   (trial_limit),
    .trial_q (trial_cnt),
    .done_q  (done)
  );
endmodule

// File: rtl/spa_checker.sv
module spa_checker #(
  parameter int unsigned LANES   = 32,
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned TRIAL_W = 16
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   clr,
  input logic                   trial_end,
  input logic [LANES*CNT_W-1:0] zero_cnt,
  input logic [LANES*CNT_W-1:0] one_cnt,
  input logic [TRIAL_W-1:0]     trial_cnt,
  input logic                   done
);
  localparam logic [TRIAL_W-1:0] TTOP = {TRIAL_W{1'b1}};
  localparam logic [CNT_W-1:0]   CTOP = {CNT_W{1'b1}};

  logic [CNT_W:0] lane0_sum;
  assign lane0_sum = {1'b0, zero_cnt[CNT_W-1:0]} + {1'b0, one_cnt[CNT_W-1:0]};

  assert_trial_step_R4: assert property (@(posedge clk) disable iff (rst)
    (trial_end && !clr && trial_cnt != TTOP) |=> trial_cnt == $past(trial_cnt) + 1'b1);

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!trial_end && !clr) |=> ($stable(trial_cnt) && $stable(zero_cnt) && $stable(one_cnt)));

  assert_lane0_one_tally_R4: assert property (@(posedge clk) disable iff (rst)
    (trial_end && !clr && zero_cnt[CNT_W-1:0] != CTOP && one_cnt[CNT_W-1:0] != CTOP)
      |=> lane0_sum == $past(lane0_sum) + 1'b1);

  assert_trial_sat_R7: assert property (@(posedge clk) disable iff (rst)
    (trial_cnt == TTOP && !clr) |=> trial_cnt == TTOP);

  assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
    clr |=> (trial_cnt == '0 && !done && zero_cnt == '0 && one_cnt == '0));

  assert_done_needs_trials_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> trial_cnt != '0);
endmodule

bind superpoly_acc spa_checker #(.LANES(LANES), .CNT_W(CNT_W), .TRIAL_W(TRIAL_W)) u_spa_checker (
  .clk       (clk),
  .rst       (rst),
  .clr       (clr),
  .trial_end (trial_end),
  .zero_cnt  (zero_cnt),
  .one_cnt   (one_cnt),
  .trial_cnt (trial_cnt),
  .done      (done)
);

// File: tb/superpoly_acc_bench.sv
module superpoly_acc_bench;
  localparam int NI = 4;
  localparam int LN = 32;
  localparam int CW = 4;
  localparam int TW = 6;
  localparam int CMAX = (1 << CW) - 1;
  localparam int TMAX = (1 << TW) - 1;

  logic clk = 1'b0;
  logic rst, clr, run_vld, trial_end, done;
  logic [NI*LN-1:0] words;
  logic [TW-1:0] lim;
  logic [LN*CW-1:0] zero_cnt, one_cnt;
  logic [TW-1:0] trial_cnt;

  int total = 0;
  int bad = 0;

  logic [LN-1:0] acc_m;
  int zc [LN];
  int oc [LN];
  int trial_m;
  logic done_m;

  always #10 clk = ~clk;

  superpoly_acc #(.NUM_INST(NI), .LANES(LN), .CNT_W(CW), .TRIAL_W(TW)) u_superpoly_acc (
    .clk(clk), .rst(rst), .clr(clr), .run_vld(run_vld), .inst_words(words),
    .trial_end(trial_end), .trial_limit(lim), .zero_cnt(zero_cnt),
    .one_cnt(one_cnt), .trial_cnt(trial_cnt), .done(done)
  );

  function automatic logic [LN-1:0] red_of(input logic [NI*LN-1:0] w);
    logic [LN-1:0] r = '0;
    for (int j = 0; j < NI; j++) r ^= w[LN*j +: LN];
    return r;
  endfunction

  function automatic logic [NI*LN-1:0] rnd_words();
    logic [NI*LN-1:0] w;
    for (int j = 0; j < NI; j++) w[LN*j +: LN] = $urandom;
    return w;
  endfunction

  task automatic model_clear();
    acc_m = '0;
    for (int i = 0; i < LN; i++) begin zc[i] = 0; oc[i] = 0; end
    trial_m = 0;
    done_m = 1'b0;
  endtask

  task automatic step(input logic rv, input logic te, input logic cl,
                      input logic [NI*LN-1:0] w);
    logic [LN-1:0] fin;
    @(negedge clk);
    run_vld = rv; trial_end = te; clr = cl; words = w;
    if (cl) begin
      model_clear();
    end else begin
      fin = acc_m ^ (rv ? red_of(w) : '0);
      if (te) begin
        for (int i = 0; i < LN; i++) begin
          if (fin[i]) begin if (oc[i] < CMAX) oc[i]++; end
          else        begin if (zc[i] < CMAX) zc[i]++; end
        end
        if (trial_m < TMAX) trial_m++;
        acc_m = '0;
      end else begin
        acc_m = fin;
      end
    end
    done_m = (lim != 0) && (trial_m >= int'(lim));
    @(posedge clk);
    #2;
  endtask

  task automatic check_all(input string tag);
    int err = 0;
    total++;
    if (int'(trial_cnt) != trial_m) begin
      err++;
      $display("FAIL %s trial_cnt actual=%0d expected=%0d", tag, trial_cnt, trial_m);
    end
    if (done !== done_m) begin
      err++;
      $display("FAIL %s done actual=%0b expected=%0b", tag, done, done_m);
    end
    for (int i = 0; i < LN; i++) begin
      if (int'(zero_cnt[CW*i +: CW]) != zc[i] || int'(one_cnt[CW*i +: CW]) != oc[i]) begin
        err++;
        $display("FAIL %s lane %0d zero/one actual=%0d/%0d expected=%0d/%0d", tag, i,
                 zero_cnt[CW*i +: CW], one_cnt[CW*i +: CW], zc[i], oc[i]);
      end
    end
    if (err != 0) bad++;
  endtask

  task automatic check_val(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [NI*LN-1:0] dw;
    void'($urandom(32'd4711));
    rst = 1'b1; clr = 1'b0; run_vld = 1'b0; trial_end = 1'b0; words = '0; lim = '0;
    model_clear();
    repeat (4) @(posedge clk);
    #2;
    check_all("R1 reset");
    @(negedge clk); rst = 1'b0;

    // R10/R2: one run of known words, then close
    dw = {32'h0000_00FF, 32'h0000_FFFF, 32'h0F0F_0000, 32'hF0F0_0000};
    step(1, 0, 0, dw);
    step(0, 1, 0, '0);
    check_all("R4 R10 single run");
    check_val("R10 lane31 one tally", int'(one_cnt[CW*31 +: CW]), 1);
    check_val("R10 lane0 zero tally", int'(zero_cnt[CW*0 +: CW]), 1);

    // R2: two identical runs cancel
    step(1, 0, 0, dw);
    step(1, 0, 0, dw);
    step(0, 1, 0, '0);
    check_all("R2 cancel");
    check_val("R2 lane31 zero tally", int'(zero_cnt[CW*31 +: CW]), 1);

    // R3: invalid words ignored
    step(0, 0, 0, rnd_words());
    step(0, 0, 0, {NI*LN{1'b1}});
    step(0, 1, 0, rnd_words());
    check_all("R3 invalid ignored");
    check_val("R3 lane31 zero tally", int'(zero_cnt[CW*31 +: CW]), 2);

    // R5: run and close in the same cycle
    step(1, 1, 0, dw);
    check_all("R5 same cycle");
    check_val("R5 lane31 one tally", int'(one_cnt[CW*31 +: CW]), 2);

    // R8: clear wins over run and close
    step(1, 0, 0, rnd_words());
    step(1, 1, 1, rnd_words());
    check_all("R8 clear priority");
    step(0, 1, 0, '0);
    check_all("R8 intermediate cleared");

    // R9 + random mix
    step(0, 0, 1, '0);
    lim = 6'd20;
    for (int t = 0; t < 30; t++) begin
      int nr = 1 + ($urandom % 4);
      for (int r = 0; r < nr; r++) step(($urandom % 4) != 0, 0, 0, rnd_words());
      step($urandom % 2, 1, 0, rnd_words());
      check_all("R4 R5 R9 random trial");
    end
    check_val("R9 done at limit", int'(done), 1);

    // R6/R7: saturate
    for (int t = 0; t < 40; t++) begin
      step(1, 0, 0, rnd_words());
      step(1, 1, 0, rnd_words());
    end
    check_all("R6 R7 saturation");
    check_val("R7 trial held", int'(trial_cnt), TMAX);
    step(1, 1, 0, rnd_words());
    check_all("R6 R7 hold after max");

    // R9: limit 0 keeps done low
    step(0, 0, 1, '0);
    lim = '0;
    for (int t = 0; t < 5; t++) begin
      step(1, 1, 0, rnd_words());
      check_all("R9 zero limit");
    end
    check_val("R9 done low with zero limit", int'(done), 0);

    // R1: reset mid-stream
    @(negedge clk); rst = 1'b1; run_vld = 1'b0; trial_end = 1'b0;
    model_clear();
    @(posedge clk); #2;
    check_all("R1 reset again");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule